// File: doc/BRIEF.md
# Format-Converting Input FIFO with Watermark Interrupt

This block sits between a host that streams geometry and colour data and a floating-point pipeline that works only on single-precision words. Each incoming beat carries a 32-bit word and a 3-bit format code. Beats are queued raw in a deep FIFO. A conversion stage at the read side turns each queued item into one or more IEEE-754 single-precision results and delivers them over a valid/ready handshake.

The accepted source formats are signed 16-bit and signed 24-bit integers, single floats passed through unchanged, and doubles sent as two beats. The block also accepts packed colour words, which hold four unsigned 8-bit channels. Occupancy is watched against two programmable thresholds. A flow-control interrupt rises when the queue grows past the upper threshold and falls only after the queue has drained beneath the lower one, so the producer is not throttled and released on every beat. A beat offered while the queue is full is discarded, and a sticky flag records the loss.

Top module: `cvt_infifo`

## Requirements
- R1: Format codes on `in_fmt` are: 0 = signed 16-bit integer in bits 15:0, with bits 31:16 ignored; 1 = signed 24-bit integer in bits 23:0, with bits 31:24 ignored; 2 = single float copied verbatim; 3 = low half of a double; 4 = high half of a double; 5 = packed colour. Codes 6 and 7 are copied verbatim like code 2.
- R2: Integer items (codes 0 and 1) are converted exactly to single precision. A zero value gives +0.0 (0x00000000).
- R3: A code-3 beat followed by a code-4 beat yields exactly one output word, the double rounded to single with round-to-nearest-even. Mantissa carry-out raises the exponent.
- R4: A double whose rounded magnitude exceeds the largest single gives a signed infinity (0x7F800000 with the sign). Exponent field 0x7FF with a zero fraction gives a signed infinity, and with a non-zero fraction gives 0x7FC00000 with the sign. Any double too small for a normal single, including zero and subnormals, gives a signed zero.
- R5: A colour beat yields four outputs, one per byte, starting with bits 7:0. Each byte is an unsigned integer converted exactly.
- R6: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values. Outputs leave in the order their beats were written.
- R7: The queue holds DEPTH beats in addition to the one result waiting in the output register.
- R8: A beat offered while the queue holds DEPTH beats is discarded. `ovf` then goes high and stays high until reset.
- R9: `irq` goes high one cycle after the queued beat count exceeds `hi_mark`. It does not go high while the count equals `hi_mark`.
- R10: Once high, `irq` stays high until the queued count is below `lo_mark`, and then clears one cycle later.
- R11: After synchronous reset, `out_valid`, `irq` and `ovf` are low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat offered this cycle |
| in_fmt | input | 3 | Format code of the beat |
| in_word | input | 32 | Beat payload |
| hi_mark | input | LVL_W (10) | Upper occupancy threshold |
| lo_mark | input | LVL_W (10) | Lower occupancy threshold |
| out_valid | output | 1 | Converted result available |
| out_ready | input | 1 | Consumer accepts result |
| out_data | output | 32 | Single-precision result |
| irq | output | 1 | Flow-control interrupt with hysteresis |
| ovf | output | 1 | Sticky dropped-write flag |

## Verification
The case hardest to reach from the ports is a write arriving at full occupancy. Reaching it requires the output register and every queue slot to be occupied while the consumer is stalled. The stimulus holds `out_ready` low and pushes DEPTH+2 numbered beats. It then drains the queue and confirms that exactly DEPTH+1 numbered results come out, in sequence. The double rounding ties and the carry into infinity are reached with hand-built bit patterns: the guard bit, the sticky bits and the kept lsb are each set independently.

// File: rtl/cvt_infifo_pkg.sv
package cvt_infifo_pkg;
  typedef logic [2:0] fmt_t;

  localparam fmt_t FMT_I16  = 3'd0;
  localparam fmt_t FMT_I24  = 3'd1;
  localparam fmt_t FMT_F32  = 3'd2;
  localparam fmt_t FMT_DLO  = 3'd3;
  localparam fmt_t FMT_DHI  = 3'd4;
  localparam fmt_t FMT_RGBA = 3'd5;

  localparam int WORD_W = 32;

  typedef struct packed {
    fmt_t              fmt;
    logic [WORD_W-1:0] word;
  } beat_t;

  localparam int BEAT_W = $bits(beat_t);
endpackage

// File: rtl/cvt_infifo_store.sv
module cvt_infifo_store #(
  parameter int W     = 35,
  parameter int DEPTH = 512,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          rvalid,
  output logic [LW-1:0] level,
  output logic          full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] mem_cnt, level_q;
  logic          head_vld;
  logic [W-1:0]  head_q;
  logic          wr_en, pop_ok, fetch;

  assign full   = (level_q == LW'(DEPTH));
  assign wr_en  = push && !full;
  assign pop_ok = pop && head_vld;
  assign fetch  = (mem_cnt != '0) && (!head_vld || pop_ok);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (fetch) head_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      mem_cnt  <= '0;
      level_q  <= '0;
      head_vld <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (fetch) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      mem_cnt <= mem_cnt + LW'(wr_en) - LW'(fetch);
      level_q <= level_q + LW'(wr_en) - LW'(pop_ok);
      if (fetch)       head_vld <= 1'b1;
      else if (pop_ok) head_vld <= 1'b0;
    end
  end

  assign rdata  = head_q;
  assign rvalid = head_vld;
  assign level  = level_q;

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (rst)
    level_q <= LW'(DEPTH));

  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (level_q <= $past(level_q)));
endmodule

// File: rtl/cvt_int2sp.sv
module cvt_int2sp (
  input  logic [23:0] val,
  output logic [31:0] sp
);
  logic        neg;
  logic [23:0] mag;
  logic [23:0] sh;
  logic [4:0]  pos;

  always_comb begin
    neg = val[23];
    mag = neg ? (~val + 24'd1) : val;
    pos = 5'd0;
    for (int i = 0; i < 24; i++) begin
      if (mag[i]) pos = 5'(i);
    end
    sh = mag << (5'd23 - pos);
    if (mag == 24'd0) sp = 32'd0;
    else              sp = {neg, 8'd127 + {3'b000, pos}, sh[22:0]};
  end

  always_comb begin
    if (val != 24'd0) assert_nonzero_kept_R2: assert (sp[30:0] != 31'd0);
  end
endmodule

// File: rtl/cvt_dp2sp.sv
module cvt_dp2sp (
  input  logic [63:0] dp,
  output logic [31:0] sp
);
  logic               sgn;
  logic [10:0]        ex;
  logic [51:0]        fr;
  logic [23:0]        keep;
  logic               guard, sticky, bump;
  logic [24:0]        sum;
  logic signed [12:0] eb;

  always_comb begin
    sgn    = dp[63];
    ex     = dp[62:52];
    fr     = dp[51:0];
    keep   = {1'b1, fr[51:29]};
    guard  = fr[28];
    sticky = |fr[27:0];
    bump   = guard && (sticky || fr[29]);
    sum    = {1'b0, keep} + {24'd0, bump};
    eb     = $signed({2'b00, ex}) - 13'sd896 + $signed({12'd0, sum[24]});
    if (ex == 11'd0)
      sp = {sgn, 31'd0};
    else if (ex == 11'h7FF)
      sp = (fr != 52'd0) ? {sgn, 8'hFF, 1'b1, 22'd0} : {sgn, 8'hFF, 23'd0};
    else if (eb >= 13'sd255)
      sp = {sgn, 8'hFF, 23'd0};
    else if (eb <= 13'sd0)
      sp = {sgn, 31'd0};
    else
      sp = {sgn, eb[7:0], sum[22:0]};
  end

  always_comb begin
    if (dp[62:52] == 11'd0) assert_flush_zero_R4: assert (sp[30:0] == 31'd0);
  end
endmodule

// File: rtl/cvt_wmark.sv
module cvt_wmark #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] hi_mark,
  input  logic [LW-1:0] lo_mark,
  output logic          irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)                  irq_q <= 1'b0;
    else if (level > hi_mark) irq_q <= 1'b1;
    else if (level < lo_mark) irq_q <= 1'b0;
  end

  assign irq = irq_q;

  assert_raise_R9: assert property (@(posedge clk) disable iff (rst)
    (level > hi_mark) |=> irq_q);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !(level < lo_mark)) |=> irq_q);

  assert_no_early_rise_R9: assert property (@(posedge clk) disable iff (rst)
    (!irq_q && !(level > hi_mark)) |=> !irq_q);
endmodule

// File: rtl/cvt_infifo.sv
module cvt_infifo
  import cvt_infifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_fmt,
  input  logic [31:0]      in_word,
  input  logic [LVL_W-1:0] hi_mark,
  input  logic [LVL_W-1:0] lo_mark,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             irq,
  output logic             ovf
);
  beat_t             in_beat, head;
  logic [BEAT_W-1:0] head_raw;
  logic              head_vld, pop, full;
  logic [LVL_W-1:0]  level;

  assign in_beat = '{fmt: in_fmt, word: in_word};
  assign head    = beat_t'(head_raw);

  cvt_infifo_store #(.W(BEAT_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rst(rst), .push(in_valid), .wdata(in_beat),
    .pop(pop), .rdata(head_raw), .rvalid(head_vld),
    .level(level), .full(full)
  );

  cvt_wmark #(.LW(LVL_W)) wmark_i (
    .clk(clk), .rst(rst), .level(level),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .irq(irq)
  );

  logic [31:0] lo_q;
  logic [1:0]  chan_q;
  logic        out_vld_q, ovf_q;
  logic [31:0] out_q;
  logic        adv, emit;
  logic [23:0] int_in;
  logic [7:0]  chan_byte;
  logic [31:0] int_sp, dbl_sp, res;

  always_comb begin
    case (chan_q)
      2'd0:    chan_byte = head.word[7:0];
      2'd1:    chan_byte = head.word[15:8];
      2'd2:    chan_byte = head.word[23:16];
      default: chan_byte = head.word[31:24];
    endcase
    case (head.fmt)
      FMT_I16:  int_in = {{8{head.word[15]}}, head.word[15:0]};
      FMT_RGBA: int_in = {16'd0, chan_byte};
      default:  int_in = head.word[23:0];
    endcase
  end

  cvt_int2sp int_i (.val(int_in), .sp(int_sp));
  cvt_dp2sp  dbl_i (.dp({head.word, lo_q}), .sp(dbl_sp));

  assign adv = !out_vld_q || out_ready;

  always_comb begin
    pop  = 1'b0;
    emit = 1'b0;
    res  = head.word;
    if (head_vld) begin
      case (head.fmt)
        FMT_DLO: pop = 1'b1;
        FMT_DHI: begin
          res = dbl_sp; emit = adv; pop = adv;
        end
        FMT_I16, FMT_I24: begin
          res = int_sp; emit = adv; pop = adv;
        end
        FMT_RGBA: begin
          res = int_sp; emit = adv; pop = adv && (chan_q == 2'd3);
        end
        default: begin
          emit = adv; pop = adv;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
      lo_q      <= '0;
      chan_q    <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (adv) out_vld_q <= emit;
      if (emit) out_q <= res;
      if (head_vld && head.fmt == FMT_DLO) lo_q <= head.word;
      if (emit && head.fmt == FMT_RGBA) chan_q <= chan_q + 2'd1;
      if (in_valid && full) ovf_q <= 1'b1;
    end
  end

  assign out_valid = out_vld_q;
  assign out_data  = out_q;
  assign ovf       = ovf_q;

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_sticky_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);

  assert_ovf_only_on_full_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(in_valid && full));
endmodule

// File: tb/cvt_infifo_tb_top.sv
`timescale 1ns/1ps
module cvt_infifo_tb_top;
  localparam int DEPTH = 512;
  localparam int LW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_fmt = '0;
  logic [31:0]   in_word = '0;
  logic [LW-1:0] hi_mark = '0;
  logic [LW-1:0] lo_mark = '0;
  logic          out_valid, out_ready = 1'b1;
  logic [31:0]   out_data;
  logic          irq, ovf;

  always #10 clk = ~clk;

  cvt_infifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_fmt(in_fmt),
    .in_word(in_word), .hi_mark(hi_mark), .lo_mark(lo_mark),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .irq(irq), .ovf(ovf)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] cap [1024];
  int cap_n = 0;
  logic [31:0] exp_q [64];
  int exp_n = 0;

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && cap_n < 1024) begin
      cap[cap_n] = out_data;
      cap_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input int hi, input int lo);
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    hi_mark = LW'(hi); lo_mark = LW'(lo);
    cycles(3);
    rst = 1'b0;
    cap_n = 0; exp_n = 0;
    cycles(1);
  endtask

  task automatic push(input logic [2:0] f, input logic [31:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1; in_fmt = f; in_word = w;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic put(input logic [2:0] f, input logic [31:0] w, input logic [31:0] e);
    push(f, w);
    exp_q[exp_n] = e;
    exp_n++;
  endtask

  task automatic put_dbl(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] e);
    push(3'd3, lo);
    put(3'd4, hi, e);
  endtask

  task automatic verify(input string tag);
    cycles(10);
    chk({tag, " count"}, 32'(cap_n), 32'(exp_n));
    for (int k = 0; k < exp_n; k++) chk(tag, cap[k], exp_q[k]);
  endtask

  task automatic t_reset;
    do_reset(8, 4);
    chk("R11 out_valid", 32'(out_valid), 32'd0);
    chk("R11 irq", 32'(irq), 32'd0);
    chk("R11 ovf", 32'(ovf), 32'd0);
  endtask

  task automatic t_int;
    do_reset(500, 1);
    put(3'd0, 32'h0000_0000, 32'h0000_0000);
    put(3'd0, 32'h0000_0001, 32'h3F80_0000);
    put(3'd0, 32'h0000_FFFF, 32'hBF80_0000);
    put(3'd0, 32'h0000_7FFF, 32'h46FF_FE00);
    put(3'd0, 32'h0000_8000, 32'hC700_0000);
    put(3'd0, 32'hABCD_0001, 32'h3F80_0000);
    put(3'd1, 32'h007F_FFFF, 32'h4AFF_FFFE);
    put(3'd1, 32'h0080_0000, 32'hCB00_0000);
    put(3'd1, 32'hFF00_0003, 32'h4040_0000);
    verify("R1 R2 integer");
  endtask

  task automatic t_float;
    do_reset(500, 1);
    put(3'd2, 32'h4049_0FDB, 32'h4049_0FDB);
    put(3'd6, 32'h1234_5678, 32'h1234_5678);
    put(3'd7, 32'hFFFF_0001, 32'hFFFF_0001);
    verify("R1 verbatim");
  endtask

  task automatic t_double;
    do_reset(500, 1);
    put_dbl(32'h3FF0_0000, 32'h0000_0000, 32'h3F80_0000);
    put_dbl(32'h3FF0_0000, 32'h1000_0000, 32'h3F80_0000);
    put_dbl(32'h3FF0_0000, 32'h3000_0000, 32'h3F80_0002);
    put_dbl(32'h3FF0_0000, 32'h1000_0001, 32'h3F80_0001);
    put_dbl(32'h3FFF_FFFF, 32'hFFFF_FFFF, 32'h4000_0000);
    verify("R3 double rounding");
    do_reset(500, 1);
    put_dbl(32'h7E30_0000, 32'h0000_0000, 32'h7F80_0000);
    put_dbl(32'hFE30_0000, 32'h0000_0000, 32'hFF80_0000);
    put_dbl(32'h47EF_FFFF, 32'hFFFF_FFFF, 32'h7F80_0000);
    put_dbl(32'h7FF0_0000, 32'h0000_0000, 32'h7F80_0000);
    put_dbl(32'h7FF8_0000, 32'h0000_0000, 32'h7FC0_0000);
    put_dbl(32'h0010_0000, 32'h0000_0000, 32'h0000_0000);
    put_dbl(32'h8010_0000, 32'h0000_0000, 32'h8000_0000);
    verify("R4 double range");
  endtask

  task automatic t_color;
    do_reset(500, 1);
    push(3'd5, 32'hFF00_0201);
    exp_q[0] = 32'h3F80_0000; exp_q[1] = 32'h4000_0000;
    exp_q[2] = 32'h0000_0000; exp_q[3] = 32'h437F_0000;
    exp_n = 4;
    put(3'd0, 32'h0000_0003, 32'h4040_0000);
    verify("R5 colour");
  endtask

  task automatic t_stall;
    do_reset(500, 1);
    out_ready = 1'b0;
    push(3'd2, 32'hAAAA_0001);
    push(3'd2, 32'hAAAA_0002);
    push(3'd2, 32'hAAAA_0003);
    cycles(6);
    chk("R6 valid under stall", 32'(out_valid), 32'd1);
    chk("R6 head under stall", out_data, 32'hAAAA_0001);
    cycles(5);
    chk("R6 data held", out_data, 32'hAAAA_0001);
    exp_q[0] = 32'hAAAA_0001; exp_q[1] = 32'hAAAA_0002; exp_q[2] = 32'hAAAA_0003;
    exp_n = 3;
    out_ready = 1'b1;
    verify("R6 order");
  endtask

  task automatic pop_one;
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    cycles(3);
  endtask

  task automatic t_wmark;
    do_reset(8, 4);
    out_ready = 1'b0;
    for (int i = 0; i < 9; i++) push(3'd2, 32'(i));
    cycles(4);
    chk("R9 level equals hi", 32'(irq), 32'd0);
    push(3'd2, 32'd9);
    cycles(3);
    chk("R9 level above hi", 32'(irq), 32'd1);
    for (int k = 0; k < 5; k++) pop_one();
    chk("R10 level at lo holds", 32'(irq), 32'd1);
    pop_one();
    chk("R10 level below lo clears", 32'(irq), 32'd0);
    out_ready = 1'b1;
    cycles(10);
  endtask

  task automatic t_overflow;
    int seq_bad;
    do_reset(DEPTH - 1, 1);
    out_ready = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) push(3'd2, 32'(i));
    cycles(4);
    chk("R8 ovf set", 32'(ovf), 32'd1);
    chk("R9 irq at full", 32'(irq), 32'd1);
    out_ready = 1'b1;
    cycles(DEPTH + 40);
    chk("R7 R8 outputs kept", 32'(cap_n), 32'(DEPTH + 1));
    seq_bad = 0;
    for (int k = 0; k < DEPTH + 1 && k < cap_n; k++) if (cap[k] !== 32'(k)) seq_bad++;
    chk("R7 sequence", 32'(seq_bad), 32'd0);
    chk("R8 ovf sticky", 32'(ovf), 32'd1);
    chk("R10 irq drained", 32'(irq), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_int();
    t_float();
    t_double();
    t_color();
    t_stall();
    t_wmark();
    t_overflow();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule